// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control half of a successive-approximation analog-to-digital converter. The DAC, the comparator and the input multiplexer are outside it. A conversion starts in one of two ways: a control write while software start is selected, or a pulse on the hardware trigger input while hardware start is selected. The block then runs a binary search of `RES_W` steps. Each step drives a trial code to the external DAC and reads back one comparator bit. When the search ends, the code is stored in a high and a low result register, and a completion flag is raised. The flag can also raise an interrupt.

The converter clock is a clock enable inside a single-clock design. Two configuration bits pick its source: a dedicated asynchronous tick, an alternate tick, or every bus cycle. A programmable power-of-two ratio then divides the chosen source. The dedicated asynchronous source is requested from outside only while a conversion is running and that source is selected. An 8-bit mode rounds the result to eight bits instead of cutting off the low bits.

Top module: `sar_seq_top`

## Requirements
- R1: With `cmp_in` high meaning "input is at or above `dac_code`", the stored result is the largest code for which the comparator answers high. The search decides one bit per converter-clock step, starting from the MSB. While a search runs, no bit below the bit under test is set in `dac_code`.
- R2: In 10-bit mode (`mode8`=0), `res_lo` holds result bits [7:0`]`, `res_hi` bits [1:0] hold result bits [9:8], and `res_hi` bits [7:2] are always zero.
- R3: In 8-bit mode (`mode8`=1), `res_lo` = min(255, (result+2)>>2) and `res_hi` = 0.
- R4: `coco` rises only on the cycle after the final search step. `irq` equals `coco` AND the stored interrupt-enable bit.
- R5: Source selection: `async_en`=1 uses `async_tick`. Otherwise `clk_sel`=0 uses `alt_tick` and `clk_sel`=1 uses every clock cycle. A search with no source tick does not advance.
- R6: `async_req` is high only while `busy` is high and `async_en` is 1.
- R7: The converter clock is the selected source divided by 2^`div_sel`. With the bus source, `coco` is first seen 10·2^`div_sel` clock edges after the starting edge.
- R8: A control write clears `coco` and aborts any running search. It loads the channel, the interrupt enable and the start mode. With software start (`ctl_hwtrig`=0) it also begins a new search.
- R9: A `rd_lo` pulse clears `coco`.
- R10: With hardware start selected, a control write begins no search and an idle `hw_trig` pulse begins one. With software start selected, `hw_trig` has no effect.
- R11: After reset, `busy`, `coco`, `irq`, `async_req`, `res_hi`, `res_lo` and `dac_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_chan | input | CH_W | Channel written by the control write |
| ctl_ien | input | 1 | Interrupt enable written by the control write |
| ctl_hwtrig | input | 1 | Start mode written: 1 = hardware trigger |
| rd_lo | input | 1 | Low result register read strobe |
| hw_trig | input | 1 | Hardware start pulse |
| async_en | input | 1 | Select dedicated asynchronous source |
| clk_sel | input | 1 | With async_en=0: 1 = bus, 0 = alternate |
| div_sel | input | DIV_W | Divide ratio exponent |
| mode8 | input | 1 | 8-bit rounded result mode |
| alt_tick | input | 1 | Alternate source tick |
| async_tick | input | 1 | Dedicated asynchronous source tick |
| cmp_in | input | 1 | Comparator: input at or above trial code |
| dac_code | output | RES_W | Trial code to the DAC |
| chan_sel | output | CH_W | Selected input channel |
| async_req | output | 1 | Request for the dedicated asynchronous source |
| busy | output | 1 | Search in progress |
| res_hi | output | 8 | High result register |
| res_lo | output | 8 | Low result register |
| coco | output | 1 | Conversion complete flag |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these invariants:
- the trial code holds no bit below the bit under test;
- the upper bits of the high register stay zero, and the whole high register is zero after an 8-bit store;
- `async_req` implies `busy`;
- `coco` rises only at the end of a search;
- `coco` falls after a control write or a low-register read.

The arithmetic value of each result can only be shown by the bench's scenarios. So can the exact latency for each divide ratio, the stall when a source gives no ticks, the restart after an abort, and the refusal of a trigger in the wrong start mode. The bench sweeps every input code in both modes against a behavioural comparator.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Width of the narrow (rounded) result and of each data register
    localparam int NARROW_W = 8;

    typedef enum logic [1:0] {
        SRC_ALT   = 2'b00,
        SRC_BUS   = 2'b01,
        SRC_ASYNC = 2'b10
    } clk_src_e;

    function automatic clk_src_e pick_src(input logic async_en, input logic clk_sel);
        if (async_en)     return SRC_ASYNC;
        else if (clk_sel) return SRC_BUS;
        else              return SRC_ALT;
    endfunction

endpackage

// File: rtl/sar_clk_gen.sv
module sar_clk_gen
    import sar_seq_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic             async_en_i,
    input  logic             clk_sel_i,
    input  logic [DIV_W-1:0] div_sel_i,
    input  logic             alt_tick_i,
    input  logic             async_tick_i,
    output logic             ck_en_o,
    output logic             async_req_o
);

    localparam int CNT_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic src_tick;
    logic [CNT_W-1:0] lim;
    clk_src_e src;

    always_comb begin
        src = pick_src(async_en_i, clk_sel_i);
        unique case (src)
            SRC_ASYNC: src_tick = async_tick_i;
            SRC_BUS:   src_tick = 1'b1;
            default:   src_tick = alt_tick_i;
        endcase
        lim     = {CNT_W{1'b1}} >> (CNT_W - int'(div_sel_i));
        ck_en_o = run_i && !restart_i && src_tick && (st_q.cnt == lim);

        st_d = st_q;
        if (restart_i || !run_i) begin
            st_d.cnt = '0;
        end else if (src_tick) begin
            st_d.cnt = (st_q.cnt == lim) ? '0 : st_q.cnt + 1'b1;
        end
        async_req_o = run_i && (src == SRC_ASYNC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    async_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        async_req_o |-> run_i);

endmodule

// File: rtl/sar_search.sv
module sar_search #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             step_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic [RES_W-1:0] trial_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);

    localparam int IDX_W = $clog2(RES_W);

    typedef struct packed {
        logic             busy;
        logic [RES_W-1:0] sar;
        logic [IDX_W-1:0] idx;
    } srch_st_t;

    srch_st_t st_d, st_q;
    logic [RES_W-1:0] decided;

    always_comb begin
        st_d    = st_q;
        done_o  = 1'b0;
        decided = st_q.sar;
        decided[st_q.idx] = cmp_i;
        result_o = decided;

        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.sar  = {1'b1, {(RES_W-1){1'b0}}};
            st_d.idx  = IDX_W'(RES_W - 1);
        end else if (stop_i) begin
            st_d.busy = 1'b0;
            st_d.sar  = '0;
        end else if (st_q.busy && step_i) begin
            if (st_q.idx == '0) begin
                st_d.busy = 1'b0;
                st_d.sar  = '0;
                done_o    = 1'b1;
            end else begin
                st_d.sar  = decided;
                st_d.sar[st_q.idx - 1'b1] = 1'b1;
                st_d.idx  = st_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o  = st_q.busy;
    assign trial_o = st_q.sar;

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (int'(st_q.idx) < RES_W));

    // R1
    low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> ((trial_o & ((RES_W'(1) << st_q.idx) - RES_W'(1))) == '0));

    // R4
    done_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> st_q.busy);

endmodule

// File: rtl/sar_result.sv
module sar_result
    import sar_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done_i,
    input  logic [RES_W-1:0]    result_i,
    input  logic                mode8_i,
    input  logic                clr_i,
    input  logic                rd_lo_i,
    output logic [NARROW_W-1:0] res_hi_o,
    output logic [NARROW_W-1:0] res_lo_o,
    output logic                coco_o
);

    localparam int SHIFT = RES_W - NARROW_W;
    localparam int HI_W  = RES_W - NARROW_W;

    typedef struct packed {
        logic [NARROW_W-1:0] hi;
        logic [NARROW_W-1:0] lo;
        logic                coco;
    } res_st_t;

    res_st_t st_d, st_q;
    logic [RES_W:0]      sum;
    logic [NARROW_W-1:0] rounded;

    always_comb begin
        sum     = {1'b0, result_i} + (RES_W+1)'(1 << (SHIFT - 1));
        rounded = sum[RES_W] ? {NARROW_W{1'b1}} : sum[RES_W-1:SHIFT];

        st_d = st_q;
        if (done_i) begin
            st_d.coco = 1'b1;
            if (mode8_i) begin
                st_d.lo = rounded;
                st_d.hi = '0;
            end else begin
                st_d.lo = result_i[NARROW_W-1:0];
                st_d.hi = NARROW_W'(result_i[RES_W-1 -: HI_W]);
            end
        end else if (clr_i || rd_lo_i) begin
            st_d.coco = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_hi_o = st_q.hi;
    assign res_lo_o = st_q.lo;
    assign coco_o   = st_q.coco;

    // R2
    hi_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hi[NARROW_W-1:HI_W] == '0);

    // R3
    narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && mode8_i) |=> (res_hi_o == '0));

    // R4
    coco_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coco_o) |-> $past(done_i));

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo_i && !done_i) |=> !coco_o);

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int DIV_W = 2,
    parameter int CH_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [CH_W-1:0]     ctl_chan,
    input  logic                ctl_ien,
    input  logic                ctl_hwtrig,
    input  logic                rd_lo,
    input  logic                hw_trig,
    input  logic                async_en,
    input  logic                clk_sel,
    input  logic [DIV_W-1:0]    div_sel,
    input  logic                mode8,
    input  logic                alt_tick,
    input  logic                async_tick,
    input  logic                cmp_in,
    output logic [RES_W-1:0]    dac_code,
    output logic [CH_W-1:0]     chan_sel,
    output logic                async_req,
    output logic                busy,
    output logic [NARROW_W-1:0] res_hi,
    output logic [NARROW_W-1:0] res_lo,
    output logic                coco,
    output logic                irq
);

    typedef struct packed {
        logic            ien;
        logic            hwmode;
        logic [CH_W-1:0] chan;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;
    logic start, ck_en, done;
    logic [RES_W-1:0] result;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d.ien    = ctl_ien;
            ctl_d.hwmode = ctl_hwtrig;
            ctl_d.chan   = ctl_chan;
        end
        start = (ctl_wr && !ctl_hwtrig) ||
                (!ctl_wr && hw_trig && ctl_q.hwmode && !busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    sar_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (busy),
        .restart_i   (ctl_wr),
        .async_en_i  (async_en),
        .clk_sel_i   (clk_sel),
        .div_sel_i   (div_sel),
        .alt_tick_i  (alt_tick),
        .async_tick_i(async_tick),
        .ck_en_o     (ck_en),
        .async_req_o (async_req)
    );

    sar_search #(.RES_W(RES_W)) u_srch (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .stop_i  (ctl_wr),
        .step_i  (ck_en),
        .cmp_i   (cmp_in),
        .busy_o  (busy),
        .trial_o (dac_code),
        .done_o  (done),
        .result_o(result)
    );

    sar_result #(.RES_W(RES_W)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done),
        .result_i(result),
        .mode8_i (mode8),
        .clr_i   (ctl_wr),
        .rd_lo_i (rd_lo),
        .res_hi_o(res_hi),
        .res_lo_o(res_lo),
        .coco_o  (coco)
    );

    assign chan_sel = ctl_q.chan;
    assign irq      = coco && ctl_q.ien;

    // R8
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !coco);

    // R10
    sw_mode_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.hwmode && !ctl_wr && !busy) |=> !busy);

endmodule

// File: tb/sim_sar_seq_top.sv
`timescale 1ns/1ps
module sim_sar_seq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 0, ctl_ien = 0, ctl_hwtrig = 0, rd_lo = 0, hw_trig = 0;
    logic [3:0] ctl_chan = '0;
    logic       async_en = 0, clk_sel = 1, mode8 = 0, alt_tick = 0, async_tick = 0;
    logic [1:0] div_sel = '0;
    logic [9:0] vin = '0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [3:0] chan_sel;
    logic       async_req, busy, coco, irq;
    logic [7:0] res_hi, res_lo;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    assign cmp_in = (vin >= dac_code);

    sar_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_chan(ctl_chan),
        .ctl_ien(ctl_ien), .ctl_hwtrig(ctl_hwtrig), .rd_lo(rd_lo), .hw_trig(hw_trig),
        .async_en(async_en), .clk_sel(clk_sel), .div_sel(div_sel), .mode8(mode8),
        .alt_tick(alt_tick), .async_tick(async_tick), .cmp_in(cmp_in),
        .dac_code(dac_code), .chan_sel(chan_sel), .async_req(async_req), .busy(busy),
        .res_hi(res_hi), .res_lo(res_lo), .coco(coco), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // Drive a control write; returns at the negedge after the write edge
    task automatic ctl_write(input logic [3:0] ch, input logic ien, input logic hw);
        @(negedge clk);
        ctl_wr = 1; ctl_chan = ch; ctl_ien = ien; ctl_hwtrig = hw;
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        hw_trig = 1;
        @(posedge clk);
        @(negedge clk);
        hw_trig = 0;
    endtask

    // Count edges until coco is seen; gives up after lim edges
    task automatic wait_done(input int lim, output int n);
        n = 0;
        while (!coco && n < lim) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        int exp8;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy == 0 && coco == 0 && irq == 0, "R11 flags", {busy, coco, irq}, 0);
        check(res_hi == 0 && res_lo == 0, "R11 results", {res_hi, res_lo}, 0);
        check(async_req == 0 && dac_code == 0, "R11 async_req/dac", {async_req, dac_code}, 0);
        rst_n = 1;

        // R1 R2 sweep in 10-bit mode, bus source, ratio 1
        for (int v = 0; v < 1024; v++) begin
            vin = 10'(v);
            ctl_write(4'd1, 0, 0);
            wait_done(200, n);
            check(n == 10, "R7 latency div1", n, 10);
            check({res_hi[1:0], res_lo} == 10'(v), "R1 result", {res_hi[1:0], res_lo}, v);
            check(res_hi[7:2] == 0, "R2 hi upper", res_hi, v >> 8);
        end

        // R3 sweep in 8-bit rounded mode
        mode8 = 1;
        for (int v = 0; v < 1024; v++) begin
            vin = 10'(v);
            ctl_write(4'd2, 0, 0);
            wait_done(200, n);
            exp8 = (v + 2) >> 2;
            if (exp8 > 255) exp8 = 255;
            check(res_lo == 8'(exp8) && res_hi == 0, "R3 rounded", {res_hi, res_lo}, exp8);
        end
        mode8 = 0;

        // R7 divide ratios
        vin = 10'd517;
        for (int d = 0; d < 4; d++) begin
            div_sel = 2'(d);
            ctl_write(4'd3, 0, 0);
            wait_done(500, n);
            check(n == 10 * (1 << d), "R7 latency", n, 10 * (1 << d));
            check({res_hi[1:0], res_lo} == 10'd517, "R7 result", {res_hi[1:0], res_lo}, 517);
        end
        div_sel = 0;

        // R4 interrupt, R9 read clear
        vin = 10'd300;
        ctl_write(4'd4, 1, 0);
        check(irq == 0 && coco == 0, "R4 irq before done", irq, 0);
        wait_done(200, n);
        check(coco == 1 && irq == 1, "R4 irq after done", irq, 1);
        @(negedge clk); rd_lo = 1;
        @(posedge clk); @(negedge clk); rd_lo = 0;
        check(coco == 0 && irq == 0, "R9 read clears", coco, 0);
        check(res_lo == 8'(300), "R9 result kept", res_lo, 300 & 255);

        // R8 abort and restart
        vin = 10'd700;
        ctl_write(4'd6, 0, 0);
        repeat (4) @(negedge clk);
        vin = 10'd123;
        ctl_write(4'd5, 0, 0);
        check(chan_sel == 5, "R8 channel", chan_sel, 5);
        check(coco == 0 && busy == 1, "R8 restarted", {coco, busy}, 1);
        wait_done(200, n);
        check(n == 10, "R8 latency after abort", n, 10);
        check({res_hi[1:0], res_lo} == 10'd123, "R8 result", {res_hi[1:0], res_lo}, 123);

        // R10 software mode ignores trigger
        pulse_trig();
        check(busy == 0 && coco == 1, "R10 trigger ignored", {busy, coco}, 1);
        // R10 hardware mode: write does not start
        vin = 10'd901;
        ctl_write(4'd7, 0, 1);
        check(busy == 0 && coco == 0, "R10 write no start", busy, 0);
        pulse_trig();
        check(busy == 1, "R10 trigger starts", busy, 1);
        wait_done(200, n);
        check(n == 9 || n == 10, "R10 latency", n, 10);
        check({res_hi[1:0], res_lo} == 10'd901, "R10 result", {res_hi[1:0], res_lo}, 901);

        // R5 R6 dedicated asynchronous source
        async_en = 1; async_tick = 0; vin = 10'd55;
        ctl_write(4'd8, 0, 0);
        repeat (20) @(negedge clk);
        check(busy == 1 && coco == 0, "R5 async stalls", busy, 1);
        check(async_req == 1, "R6 async_req high", async_req, 1);
        async_tick = 1;
        wait_done(200, n);
        check(n == 10, "R5 async latency", n, 10);
        check(async_req == 0, "R6 async_req idle", async_req, 0);
        check({res_hi[1:0], res_lo} == 10'd55, "R5 async result", {res_hi[1:0], res_lo}, 55);

        // R5 R6 alternate source
        async_en = 0; clk_sel = 0; alt_tick = 0; vin = 10'd999;
        ctl_write(4'd9, 0, 0);
        repeat (20) @(negedge clk);
        check(busy == 1 && coco == 0, "R5 alt stalls", busy, 1);
        check(async_req == 0, "R6 async_req not alt", async_req, 0);
        alt_tick = 1;
        wait_done(200, n);
        check(n == 10, "R5 alt latency", n, 10);
        check({res_hi[1:0], res_lo} == 10'd999, "R5 alt result", {res_hi[1:0], res_lo}, 999);

        finish_run();
    end

endmodule